// File: doc/BRIEF.md
# Access side-effect register file

A small register file in which every field changes state as a consequence of the software access that touches it, not through hardware update inputs. A read can clear a field or fill it with ones. A write can set, clear or toggle bits selected by ones or by zeros in the write data, or clear or fill a field whatever data is written. Fields without a read action hold ordinary write data.

The port is a single synchronous CPU access port. The register index is taken from the byte address at a 4-byte stride. Read data is combinational and shows the value the field held before the access. The side effect lands on the clock edge that accepts the access. Each field also drives a one-cycle strobe that marks software modification. One field is exported as a hardware-visible value.

Top module: `sefx_regfile`

## Requirements
- R1: After reset, reads return 0x00000FF0 at 0x0, 0x000000F0 at 0x4 and at 0x8, and 0x00000FF0 at 0xC. `cnt_q_o` is 30 (0x1E) before any access.
- R2: Read data is valid combinationally in the cycle where `req_i`=1 and `we_i`=0. It holds the value before that read's side effect, and the side effect is visible from the next cycle.
- R3: At 0x0, a read clears bits [7:0] and sets bits [15:8] to all ones. Two reads after reset return 0x0FF0 and then 0xFF00.
- R4: A write to 0x0 stores `wdata_i[15:0]` unchanged. For example, a write of 0x00FF reads back as 0x00FF, and the following read returns 0xFF00.
- R5: At 0x4, each 1 in the write data does the following: in bits [3:0] it sets the bit, in bits [7:4] it clears the bit, and in bits [11:8] it toggles the bit. A 0 leaves the bit unchanged.
- R6: At 0x8, each 0 in the write data does the following: in bits [3:0] it sets the bit, in bits [7:4] it clears the bit, and in bits [11:8] it toggles the bit. A 1 leaves the bit unchanged.
- R7: Any write to 0xC clears bits [7:0] and sets bits [15:8], whatever the data. The register then reads 0xFF00.
- R8: The field at 0x10 occupies bits [7:0] and is visible on `cnt_q_o`. A read returns its current value and sets it to 0 on that edge. A write stores `wdata_i[7:0]`. Between accesses it holds its value.
- R9: `swmod_o` bit i is high, for that cycle only, in two cases: when field i is written, and when field i is read and has a read action. The field order, LSB first, is: 0x0[7:0], 0x0[15:8], 0x4[3:0], 0x4[7:4], 0x4[11:8], 0x8[3:0], 0x8[7:4], 0x8[11:8], 0xC[7:0], 0xC[15:8], 0x10[7:0]. With `req_i`=0, or on a read of 0x4, 0x8 or 0xC, all bits are 0.
- R10: Unused bits of a register read as 0. Addresses from 0x14 upward read 0, and writes to them change no field and raise no `swmod_o` bit.
- R11: Address bits [1:0] are ignored. While `req_i`=0, `we_i`, `addr_i` and `wdata_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access accepted this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (8) | Byte address |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data, pre-side-effect value |
| swmod_o | output | 11 | Per-field software-modify strobe |
| cnt_q_o | output | 8 | Current value of the field at 0x10 |

## Verification
The bound checker watches the field at 0x10 on every cycle. Its read data must match its pre-read value, it must become zero after a read, and it must hold between accesses. The checker also checks that no strobe fires without a request or on a read of a write-action register, that strobe groups fire for whole registers on a write, and that unused read bits stay 0. The bench alone can show the arithmetic of each write action. It sweeps every 12-bit write pattern through the one-set and zero-set registers against a running model, and it exercises the read-then-read ordering on 0x0, the data independence at 0xC, and the unmapped and gated accesses.

// File: rtl/sefx_pkg.sv
package sefx_pkg;
  typedef enum logic [3:0] {
    ACT_RCLR, ACT_RSET,
    ACT_W1S, ACT_W1C, ACT_W1T,
    ACT_W0S, ACT_W0C, ACT_W0T,
    ACT_WCLR, ACT_WSET
  } act_e;

  localparam int NUM_REGS   = 5;
  localparam int NUM_FIELDS = 11;
  localparam int MAX_FW     = 8;

  function automatic int fld_reg(int i);
    case (i)
      0, 1:    return 0;
      2, 3, 4: return 1;
      5, 6, 7: return 2;
      8, 9:    return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int fld_lsb(int i);
    case (i)
      1, 9:    return 8;
      3, 6:    return 4;
      4, 7:    return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int fld_width(int i);
    return (i >= 2 && i <= 7) ? 4 : 8;
  endfunction

  function automatic logic [MAX_FW-1:0] fld_reset(int i);
    case (i)
      0, 8:    return 8'hF0;
      1, 9:    return 8'h0F;
      3, 6:    return 8'h0F;
      10:      return 8'd30;
      default: return 8'h00;
    endcase
  endfunction

  function automatic act_e fld_act(int i);
    case (i)
      0:       return ACT_RCLR;
      1:       return ACT_RSET;
      2:       return ACT_W1S;
      3:       return ACT_W1C;
      4:       return ACT_W1T;
      5:       return ACT_W0S;
      6:       return ACT_W0C;
      7:       return ACT_W0T;
      8:       return ACT_WCLR;
      9:       return ACT_WSET;
      default: return ACT_RCLR;
    endcase
  endfunction
endpackage

// File: rtl/sefx_decode.sv
module sefx_decode #(
  parameter int AW = 8,
  parameter int NR = 5
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic [NR-1:0] rd_sel_o,
  output logic [NR-1:0] wr_sel_o
);
  localparam int IW = AW - 2;

  logic [IW-1:0] idx;
  assign idx = addr_i[AW-1:2];

  for (genvar r = 0; r < NR; r++) begin : g_sel
    logic hit;
    assign hit         = req_i && (idx == IW'(r));
    assign rd_sel_o[r] = hit && !we_i;
    assign wr_sel_o[r] = hit && we_i;
  end
endmodule

// File: rtl/sefx_field.sv
module sefx_field
  import sefx_pkg::*;
#(
  parameter int           W   = 8,
  parameter act_e         ACT = ACT_RCLR,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic         swmod_o
);
  logic [W-1:0] q, nxt;
  logic         mod;

  always_comb begin
    nxt = q;
    mod = 1'b0;
    if (wr_i) begin
      mod = 1'b1;
      case (ACT)
        ACT_W1S:  nxt = q | wdata_i;
        ACT_W1C:  nxt = q & ~wdata_i;
        ACT_W1T:  nxt = q ^ wdata_i;
        ACT_W0S:  nxt = q | ~wdata_i;
        ACT_W0C:  nxt = q & wdata_i;
        ACT_W0T:  nxt = q ^ ~wdata_i;
        ACT_WCLR: nxt = '0;
        ACT_WSET: nxt = '1;
        default:  nxt = wdata_i;  // read-action fields store plain data
      endcase
    end else if (rd_i) begin
      case (ACT)
        ACT_RCLR: begin nxt = '0; mod = 1'b1; end
        ACT_RSET: begin nxt = '1; mod = 1'b1; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q <= RST;
    else if (mod) q <= nxt;
  end

  assign q_o     = q;
  assign swmod_o = mod;
endmodule

// File: rtl/sefx_regfile.sv
module sefx_regfile
  import sefx_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  output logic [NUM_FIELDS-1:0] swmod_o,
  output logic [7:0]            cnt_q_o
);
  localparam int NF    = NUM_FIELDS;
  localparam int CNT_W = fld_width(NF-1);

  logic [NUM_REGS-1:0]         rd_sel, wr_sel;
  logic [NF-1:0][DW-1:0]       contrib;
  logic [NF-1:0][MAX_FW-1:0]   fq;

  sefx_decode #(.AW(AW), .NR(NUM_REGS)) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .rd_sel_o (rd_sel),
    .wr_sel_o (wr_sel)
  );

  for (genvar g = 0; g < NF; g++) begin : g_fld
    localparam int              R  = fld_reg(g);
    localparam int              L  = fld_lsb(g);
    localparam int              W  = fld_width(g);
    localparam act_e            A  = fld_act(g);
    localparam logic [MAX_FW-1:0] RV = fld_reset(g);

    logic [W-1:0] q;

    sefx_field #(.W(W), .ACT(A), .RST(RV[W-1:0])) u_fld (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rd_i    (rd_sel[R]),
      .wr_i    (wr_sel[R]),
      .wdata_i (wdata_i[L +: W]),
      .q_o     (q),
      .swmod_o (swmod_o[g])
    );

    assign fq[g]      = MAX_FW'(q);
    assign contrib[g] = rd_sel[R] ? (DW'(q) << L) : '0;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NF; i++) rdata_o = rdata_o | contrib[i];
  end

  assign cnt_q_o = 8'(fq[NF-1][CNT_W-1:0]);

  logic unused_bits;
  assign unused_bits = ^{wdata_i[DW-1:16], addr_i[1:0], fq};
endmodule

// File: rtl/sefx_regfile_chk.sv
module sefx_regfile_chk #(
  parameter int AW = 8,
  parameter int NF = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [31:0]   rdata_o,
  input logic [NF-1:0] swmod_o,
  input logic [7:0]    cnt_q_o
);
  localparam int IW = AW - 2;

  logic [IW-1:0] idx;
  logic          rd_cnt, wr_cnt;
  assign idx    = addr_i[AW-1:2];
  assign rd_cnt = req_i && !we_i && idx == IW'(4);
  assign wr_cnt = req_i && we_i && idx == IW'(4);

  // R2: read data shows the pre-side-effect value
  a_r2_pre_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt |-> rdata_o[7:0] == cnt_q_o);

  // R8: read clears, idle holds
  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt |=> cnt_q_o == 8'd0);

  a_r8_holds_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_cnt || wr_cnt) |=> $stable(cnt_q_o));

  // R9: strobe behaviour
  a_r9_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> swmod_o == '0);

  a_r9_quiet_wact_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (idx == IW'(1) || idx == IW'(2) || idx == IW'(3)))
    |-> swmod_o == '0);

  a_r9_write_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx == IW'(1)) |-> swmod_o == NF'(11'h01C));

  a_r9_single_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && idx == IW'(4) |-> $onehot0(swmod_o));

  // R10: unused bits of the 12-bit registers read zero
  a_r10_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && idx == IW'(2)) |-> rdata_o[31:12] == '0);
endmodule

bind sefx_regfile sefx_regfile_chk #(.AW(AW), .NF(sefx_pkg::NUM_FIELDS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .swmod_o (swmod_o),
  .cnt_q_o (cnt_q_o)
);

// File: tb/sefx_regfile_test.sv
module sefx_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [10:0] swmod;
  logic [7:0]  cnt_q;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sefx_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .swmod_o(swmod), .cnt_q_o(cnt_q)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic [10:0] sm);
    @(negedge clk);
    req = 1'b1; we = wr; addr = a; wdata = d;
    #5;
    rd = rdata; sm = swmod;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] r; logic [10:0] s;
    access(1'b0, a, '0, r, s);
    check(tag, r, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [10:0] s;
    logic [11:0] m;
    logic [7:0]  c;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 cnt reset", 32'(cnt_q), 32'd30);
    rd_chk("R1 reg4", 8'h04, 32'h0F0);
    rd_chk("R1 reg8", 8'h08, 32'h0F0);
    rd_chk("R1 regC", 8'h0C, 32'h0FF0);

    // R3 / R2 read actions, strobes on read
    access(1'b0, 8'h00, '0, r, s);
    check("R3 first read", r, 32'h0FF0);
    check("R9 read strobe", 32'(s), 32'h003);
    access(1'b0, 8'h00, '0, r, s);
    check("R2 second read", r, 32'hFF00);
    access(1'b0, 8'h04, '0, r, s);
    check("R9 no strobe wact read", 32'(s), 32'h0);

    // R4 plain writes to the read-action register, upper bits junk (R10)
    for (int k = 0; k < 256; k++) begin
      logic [15:0] d;
      d = {k[7:0], ~k[7:0]};
      access(1'b1, 8'h00, {16'hA5C3, d}, r, s);
      check("R9 write strobe reg0", 32'(s), 32'h003);
      rd_chk("R4 stored", 8'h00, {16'h0, d});
      rd_chk("R3 after read", 8'h00, 32'hFF00);
    end

    // R5 one-action sweep
    m = 12'h0F0;
    for (int k = 0; k < 4096; k++) begin
      logic [11:0] d;
      d = k[11:0];
      access(1'b1, 8'h04, {20'hBEEF1, d}, r, s);
      check("R9 write strobe reg4", 32'(s), 32'h01C);
      m = {m[11:8] ^ d[11:8], m[7:4] & ~d[7:4], m[3:0] | d[3:0]};
      rd_chk("R5 one-action", 8'h04, {20'h0, m});
    end

    // R6 zero-action sweep
    m = 12'h0F0;
    for (int k = 0; k < 4096; k++) begin
      logic [11:0] d;
      d = 12'(k * 7 + 3);
      access(1'b1, 8'h08, {20'h5A5A5, d}, r, s);
      check("R9 write strobe reg8", 32'(s), 32'h0E0);
      m = {m[11:8] ^ ~d[11:8], m[7:4] & d[7:4], m[3:0] | ~d[3:0]};
      rd_chk("R6 zero-action", 8'h08, {20'h0, m});
    end

    // R7 any-write clear / set
    for (int k = 0; k < 256; k++) begin
      access(1'b1, 8'h0C, {k[7:0], 8'h12, k[7:0], 8'h34}, r, s);
      check("R9 write strobe regC", 32'(s), 32'h300);
      rd_chk("R7 any write", 8'h0C, 32'hFF00);
    end

    // R8 read-clear counter field
    access(1'b0, 8'h10, '0, r, s);
    check("R8 read value", r, 32'd30);
    check("R9 cnt strobe", 32'(s), 32'h400);
    check("R8 cleared", 32'(cnt_q), 32'h0);
    @(negedge clk); #5;
    check("R9 strobe low idle", 32'(swmod), 32'h0);
    check("R8 hold", 32'(cnt_q), 32'h0);
    for (int k = 1; k < 256; k += 17) begin
      access(1'b1, 8'h10, {24'hFFFFFF, k[7:0]}, r, s);
      check("R8 write", 32'(cnt_q), 32'(k[7:0]));
      access(1'b0, 8'h10, '0, r, s);
      check("R8 read pre", r, 32'(k[7:0]));
      check("R8 read clears", 32'(cnt_q), 32'h0);
    end
    access(1'b1, 8'h10, 32'h66, r, s);

    // R10 unmapped space
    for (int k = 5; k < 64; k++) begin
      access(1'b1, 8'(k * 4), 32'hFFFFFFFF, r, s);
      check("R10 unmapped strobe", 32'(s), 32'h0);
      access(1'b0, 8'(k * 4 + 1), '0, r, s);
      check("R10 unmapped read", r, 32'h0);
      check("R10 unmapped strobe rd", 32'(s), 32'h0);
    end
    rd_chk("R10 reg4 kept", 8'h04, {20'h0, 12'h000} | 32'(uut_reg4_model()));
    rd_chk("R10 reg8 kept", 8'h08, 32'(uut_reg8_model()));
    check("R10 cnt kept", 32'(cnt_q), 32'h66);

    // R11 gated request and ignored low address bits
    @(negedge clk);
    req = 1'b0; we = 1'b1; addr = 8'h10; wdata = 32'h99;
    @(posedge clk); #1;
    we = 1'b0;
    check("R11 gated write", 32'(cnt_q), 32'h66);
    access(1'b1, 8'h13, 32'h5C, r, s);
    check("R11 low bits ignored", 32'(cnt_q), 32'h5C);
    c = cnt_q;
    access(1'b0, 8'h12, '0, r, s);
    check("R11 low bits read", r, 32'(c));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // final state of the sweeps, recomputed arithmetically
  function automatic logic [11:0] uut_reg4_model();
    logic [11:0] mm = 12'h0F0;
    for (int k = 0; k < 4096; k++) begin
      logic [11:0] d = k[11:0];
      mm = {mm[11:8] ^ d[11:8], mm[7:4] & ~d[7:4], mm[3:0] | d[3:0]};
    end
    return mm;
  endfunction

  function automatic logic [11:0] uut_reg8_model();
    logic [11:0] mm = 12'h0F0;
    for (int k = 0; k < 4096; k++) begin
      logic [11:0] d = 12'(k * 7 + 3);
      mm = {mm[11:8] ^ ~d[11:8], mm[7:4] & d[7:4], mm[3:0] | ~d[3:0]};
    end
    return mm;
  endfunction
endmodule